// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches over a processor that must write to it at intervals. A prescaler splits the clock into ticks, and each tick moves a down-counter one step. When the counter first runs out, the block sends a one-cycle interrupt pulse and reloads the counter with a shorter grace period. If software does not reload the watchdog during that grace period, a second expiry sends a one-cycle system reset pulse. That pulse returns the block to its power-up settings, and the block records the watchdog cause code in a status output.

Software reloads the watchdog with one 32-bit write that holds three fields: the count, the prescaler and the grace period. A second write target, the trapdoor, can switch the watchdog off. It works only while the block is still in its power-up state, before any reload has been written. Once switched off, the watchdog halts at its next tick. A later reload starts it again.

Top module: `wdt_core`

## Requirements
- R1: After `rst_n` is released, `irq_pulse` and `sys_rst_pulse` are low and `cause` is 0. The block starts counting at once, in its initial state, with the parameter defaults: prescaler `RST_SCALE` (255), count `RST_COUNT` (0xFFFF) and grace period `RST_DELAY` (255).
- R2: A write with `wr_en`=1 and `wr_sel`=0 is a reload. It takes the count from `wr_data[15:0]`, the prescaler from `wr_data[23:16]` and the grace period from `wr_data[31:24]`.
- R3: The counter steps down once every (prescaler+1) clock cycles, with the prescale phase restarted by each reload. For a reload sampled at clock edge E with prescaler S and count C, the first expiry falls on edge E+(C+1)(S+1).
- R4: The first expiry gives `irq_pulse` high for exactly one cycle, after that edge. It arms the reset stage and loads the counter with the grace period D.
- R5: An expiry while armed gives `sys_rst_pulse` high for exactly one cycle, on edge E+(C+D+2)(S+1). At the same edge `cause` becomes 0xC000.
- R6: The reset pulse returns the prescaler, count, grace period and state to their R1 values. The next interrupt then comes (RST_COUNT+1)(RST_SCALE+1) cycles after the pulse edge.
- R7: A write with `wr_en`=1 and `wr_sel`=1 is a trapdoor write. In the initial state it disables the watchdog. The disabled watchdog moves to a halted state at its next tick and then gives no interrupt and no reset.
- R8: A reload from the disabled or halted state restarts counting under the timing of R3.
- R9: A trapdoor write in any state other than the initial one has no effect. A running watchdog keeps the timing of R3 through R5.
- R10: A reload always disarms the reset stage. A reload made after the interrupt leads to another interrupt, not to a reset.
- R11: `cause` keeps 0xC000 across the block's own reset and later activity. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 reload, 1 trapdoor |
| wr_data | input | 32 | Reload word: count [15:0], prescaler [23:16], grace period [31:24] |
| irq_pulse | output | 1 | One-cycle pulse on the first expiry |
| sys_rst_pulse | output | 1 | One-cycle system reset pulse on the second expiry |
| cause | output | 16 | Reset cause: 0 after `rst_n`, 0xC000 after a watchdog reset |

## Verification
The hardest case to reach from the ports is the trapdoor path. It only works in the power-up state, and that state ends either at the first reload or after a very long default timeout. The bench therefore builds the block with small default parameters, so that counting in the initial state and the self-reset can both be seen within a few hundred cycles. It writes the trapdoor in the first cycles after `rst_n` is released, then watches a window several times longer than the default timeout for silence. It also sends reloads while the reset stage is armed and trapdoor writes while running, to show that the first disarms the reset and the second is ignored.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WD_INIT = 2'd0,
    WD_OFF  = 2'd1,
    WD_RUN  = 2'd2,
    WD_HALT = 2'd3
  } wd_state_e;

  localparam logic [15:0] CAUSE_WDOG = 16'hC000;

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned SCALE_W = 8,
  parameter logic [SCALE_W-1:0] RST_SCALE = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [SCALE_W-1:0] reload_val,
  output logic               tick
);

  logic [SCALE_W-1:0] pcnt_q;

  assign tick = run && (pcnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= RST_SCALE;
    end else if (restart) begin
      pcnt_q <= reload_val;
    end else if (run) begin
      if (pcnt_q == '0) pcnt_q <= reload_val;
      else              pcnt_q <= pcnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SCALE_W = 8,
  parameter int unsigned DELAY_W = 8,
  parameter logic [SCALE_W-1:0] RST_SCALE = '1,
  parameter logic [CNT_W-1:0]   RST_COUNT = '1,
  parameter logic [DELAY_W-1:0] RST_DELAY = '1,
  localparam int unsigned DATA_W = CNT_W + SCALE_W + DELAY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_wr,
  input  logic               trap_wr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               tick,
  output logic               run,
  output logic [SCALE_W-1:0] scale_nxt,
  output wd_state_e          state_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [DELAY_W-1:0] delay_o,
  output logic               armed_o,
  output logic               irq_o,
  output logic               sysrst_o,
  output logic               hit_rst
);

  function automatic logic [CNT_W-1:0] f_count(input logic [DATA_W-1:0] d);
    return d[CNT_W-1:0];
  endfunction

  function automatic logic [SCALE_W-1:0] f_scale(input logic [DATA_W-1:0] d);
    return d[CNT_W +: SCALE_W];
  endfunction

  function automatic logic [DELAY_W-1:0] f_delay(input logic [DATA_W-1:0] d);
    return d[CNT_W+SCALE_W +: DELAY_W];
  endfunction

  function automatic logic [CNT_W-1:0] widen(input logic [DELAY_W-1:0] v);
    return CNT_W'(v);
  endfunction

  wd_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SCALE_W-1:0] scale_q;
  logic [DELAY_W-1:0] delay_q;
  logic               armed_q, irq_q, sysrst_q;

  logic trap_ok, counting, expire, hit_irq, step, go_halt;

  assign trap_ok  = trap_wr && (state_q == WD_INIT);
  assign counting = tick && !load_wr && !trap_ok &&
                    ((state_q == WD_INIT) || (state_q == WD_RUN));
  assign expire   = counting && (cnt_q == '0);
  assign hit_irq  = expire && !armed_q;
  assign hit_rst  = expire && armed_q;
  assign step     = counting && (cnt_q != '0);
  assign go_halt  = tick && !load_wr && (state_q == WD_OFF);

  assign run       = (state_q != WD_HALT);
  assign scale_nxt = load_wr ? f_scale(wr_data) :
                     hit_rst ? RST_SCALE : scale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WD_INIT;
      cnt_q    <= RST_COUNT;
      scale_q  <= RST_SCALE;
      delay_q  <= RST_DELAY;
      armed_q  <= 1'b0;
      irq_q    <= 1'b0;
      sysrst_q <= 1'b0;
    end else begin
      irq_q    <= hit_irq;
      sysrst_q <= hit_rst;
      if (load_wr) begin
        cnt_q   <= f_count(wr_data);
        scale_q <= f_scale(wr_data);
        delay_q <= f_delay(wr_data);
        armed_q <= 1'b0;
        state_q <= WD_RUN;
      end else if (trap_ok) begin
        state_q <= WD_OFF;
      end else if (hit_rst) begin
        state_q <= WD_INIT;
        cnt_q   <= RST_COUNT;
        scale_q <= RST_SCALE;
        delay_q <= RST_DELAY;
        armed_q <= 1'b0;
      end else if (hit_irq) begin
        armed_q <= 1'b1;
        cnt_q   <= widen(delay_q);
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (go_halt) begin
        state_q <= WD_HALT;
      end
    end
  end

  assign state_o  = state_q;
  assign count_o  = cnt_q;
  assign delay_o  = delay_q;
  assign armed_o  = armed_q;
  assign irq_o    = irq_q;
  assign sysrst_o = sysrst_q;

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SCALE_W   = 8,
  parameter int unsigned DELAY_W   = 8,
  parameter int unsigned RST_SCALE = 255,
  parameter int unsigned RST_COUNT = 65535,
  parameter int unsigned RST_DELAY = 255
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             wr_sel,
  input  logic [CNT_W+SCALE_W+DELAY_W-1:0] wr_data,
  output logic                             irq_pulse,
  output logic                             sys_rst_pulse,
  output logic [15:0]                      cause
);

  localparam logic [SCALE_W-1:0] SCALE_DEF = SCALE_W'(RST_SCALE);
  localparam logic [CNT_W-1:0]   COUNT_DEF = CNT_W'(RST_COUNT);
  localparam logic [DELAY_W-1:0] DELAY_DEF = DELAY_W'(RST_DELAY);

  logic               load_wr, trap_wr, tick, run, hit_rst;
  logic [SCALE_W-1:0] scale_nxt;
  wd_state_e          fsm_state;
  logic [CNT_W-1:0]   fsm_cnt;
  logic [DELAY_W-1:0] fsm_delay;
  logic               fsm_armed;
  logic [15:0]        cause_q;

  assign load_wr = wr_en && !wr_sel;
  assign trap_wr = wr_en && wr_sel;

  wdt_prescale #(
    .SCALE_W   (SCALE_W),
    .RST_SCALE (SCALE_DEF)
  ) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .restart    (load_wr),
    .reload_val (scale_nxt),
    .tick       (tick)
  );

  wdt_fsm #(
    .CNT_W     (CNT_W),
    .SCALE_W   (SCALE_W),
    .DELAY_W   (DELAY_W),
    .RST_SCALE (SCALE_DEF),
    .RST_COUNT (COUNT_DEF),
    .RST_DELAY (DELAY_DEF)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_wr   (load_wr),
    .trap_wr   (trap_wr),
    .wr_data   (wr_data),
    .tick      (tick),
    .run       (run),
    .scale_nxt (scale_nxt),
    .state_o   (fsm_state),
    .count_o   (fsm_cnt),
    .delay_o   (fsm_delay),
    .armed_o   (fsm_armed),
    .irq_o     (irq_pulse),
    .sysrst_o  (sys_rst_pulse),
    .hit_rst   (hit_rst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cause_q <= '0;
    else if (hit_rst) cause_q <= CAUSE_WDOG;
  end

  assign cause = cause_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DELAY_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               wr_sel,
  input logic               irq_pulse,
  input logic               sys_rst_pulse,
  input logic [15:0]        cause,
  input wd_state_e          state,
  input logic [CNT_W-1:0]   cnt,
  input logic [DELAY_W-1:0] delay,
  input logic               armed
);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R4

  AST_IRQ_ARMS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (armed && cnt == CNT_W'(delay))); // R4

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse); // R5

  AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> $past(armed)); // R5

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> (cause == CAUSE_WDOG)); // R5

  AST_RST_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> (state == WD_INIT && !armed)); // R6

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_HALT && !wr_en) |=> (state == WD_HALT && $stable(cnt))); // R7

  AST_TRAP_LATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && state == WD_RUN) |=> (state != WD_OFF)); // R9

endmodule

bind wdt_core wdt_checker #(
  .CNT_W   (CNT_W),
  .DELAY_W (DELAY_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_sel        (wr_sel),
  .irq_pulse     (irq_pulse),
  .sys_rst_pulse (sys_rst_pulse),
  .cause         (cause),
  .state         (fsm_state),
  .cnt           (fsm_cnt),
  .delay         (fsm_delay),
  .armed         (fsm_armed)
);

// File: tb/wdt_core_bench.sv
module wdt_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEF_S = 3;
  localparam int DEF_C = 20;
  localparam int DEF_D = 5;
  localparam int DEF_IRQ = (DEF_C + 1) * (DEF_S + 1);
  localparam int DEF_RST = (DEF_C + DEF_D + 2) * (DEF_S + 1);
  localparam int NVEC = 4;
  localparam logic [31:0] VEC [NVEC] = '{32'h0000_0000, 32'h0203_0005,
                                         32'h0001_0007, 32'h0407_0002};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        irq_pulse, sys_rst_pulse;
  logic [15:0] cause;

  int cyc = 0;
  int irq_n = 0, rst_cnt = 0, irq_at = -1, rst_at = -1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  wdt_core #(
    .RST_SCALE (DEF_S),
    .RST_COUNT (DEF_C),
    .RST_DELAY (DEF_D)
  ) u_wdt_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .irq_pulse     (irq_pulse),
    .sys_rst_pulse (sys_rst_pulse),
    .cause         (cause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (irq_pulse)     begin irq_n++;   irq_at = cyc; end
    if (sys_rst_pulse) begin rst_cnt++; rst_at = cyc; end
  end

  function automatic int first_exp(input logic [31:0] w);
    int s = int'(w / 65536) % 256;
    int c = int'(w % 65536);
    return (c + 1) * (s + 1);
  endfunction

  function automatic int second_exp(input logic [31:0] w);
    int s = int'(w / 65536) % 256;
    int c = int'(w % 65536);
    int d = int'(w / 16777216);
    return (c + d + 2) * (s + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_write(input logic sel, input logic [31:0] d, output int w);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    w = cyc;
    wr_en = 1'b0; wr_sel = 1'b0;
  endtask

  task automatic wait_irq(input int n0, input int limit);
    for (int i = 0; i < limit && irq_n == n0; i++) @(posedge clk);
  endtask

  task automatic wait_rst(input int n0, input int limit);
    for (int i = 0; i < limit && rst_cnt == n0; i++) @(posedge clk);
  endtask

  task automatic apply_reset(output int r0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    r0 = cyc;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int r0, w, n0, m0, rs;

    // R1: reset values and counting from the initial state
    apply_reset(r0);
    chk("R1 irq low after reset", int'(irq_pulse), 0);
    chk("R1 sys_rst low after reset", int'(sys_rst_pulse), 0);
    chk("R1 cause cleared", int'(cause), 0);
    wait_irq(0, 500);
    chk("R1 first irq with default settings", irq_at, r0 + DEF_IRQ);
    wait_rst(0, 500);
    chk("R5 reset timing with defaults", rst_at, r0 + DEF_RST);
    chk("R5 cause after watchdog reset", int'(cause), 16'hC000);
    rs = rst_at;
    @(negedge clk);
    chk("R5 reset pulse single cycle", int'(sys_rst_pulse), 0);

    // R6: defaults restored by the reset pulse
    n0 = irq_n;
    wait_irq(n0, 500);
    chk("R6 irq after self reset", irq_at, rs + DEF_IRQ);
    chk("R11 cause kept after self reset", int'(cause), 16'hC000);

    // R2, R3, R4, R5, R10: vector table, first load made while armed
    for (int k = 0; k < NVEC; k++) begin
      n0 = irq_n; m0 = rst_cnt;
      do_write(1'b0, VEC[k], w);
      wait_rst(m0, 2000);
      chk("R3 first expiry edge", irq_at, w + first_exp(VEC[k]));
      chk("R2 R5 second expiry edge", rst_at, w + second_exp(VEC[k]));
      chk("R4 R10 exactly one irq before reset", irq_n - n0, 1);
      chk("R5 cause code", int'(cause), 16'hC000);
    end

    // R9: trapdoor while running is ignored
    n0 = irq_n; m0 = rst_cnt;
    do_write(1'b0, 32'h0102_0003, w);
    do_write(1'b1, 32'h0, r0);
    wait_rst(m0, 2000);
    chk("R9 irq unchanged by late trapdoor", irq_at, w + first_exp(32'h0102_0003));
    chk("R9 reset unchanged by late trapdoor", rst_at, w + second_exp(32'h0102_0003));

    // R11: only rst_n clears the cause
    chk("R11 cause before rst_n", int'(cause), 16'hC000);
    apply_reset(r0);
    chk("R11 cause cleared by rst_n", int'(cause), 0);

    // R7: trapdoor from the initial state silences the block
    n0 = irq_n; m0 = rst_cnt;
    do_write(1'b1, 32'h0, w);
    repeat (4 * DEF_RST) @(posedge clk);
    @(negedge clk);
    chk("R7 no irq once disabled", irq_n - n0, 0);
    chk("R7 no reset once disabled", rst_cnt - m0, 0);

    // R8: reload from halted restarts counting
    do_write(1'b0, 32'h0001_0003, w);
    wait_rst(m0, 2000);
    chk("R8 irq after restart", irq_at, w + first_exp(32'h0001_0003));
    chk("R8 reset after restart", rst_at, w + second_exp(32'h0001_0003));

    summary();
  end

endmodule